// File: doc/BRIEF.md
# Pipelined GF(2^m) Power-Sum Unit

This block evaluates P = C + A·B² over the binary extension field GF(2^m). Elements are m-bit vectors in polynomial basis, so bit i is the coefficient of x^i. The field width and the reduction polynomial are parameters. All three operands arrive in parallel on one clock edge, and the m-bit result leaves in parallel.

The squaring of B is done by a combinational network at the input. The product and the sum come from a one-directional chain of m identical cells, and each cell consumes one bit of A, starting with the most significant bit. Operands are delayed through skew registers, so every cell works on the values of its own operand set. A new operand set can enter on every clock. A valid flag travels with the data through the chain. Typical uses are inversion and division schedules, where the block is called repeatedly with new operands on every clock.

Top module: `gf_power_sum`

## Requirements
- R1: When `out_valid` is high, `p_out` equals C xor (A·B² mod F), where F is the parameter polynomial and A, B, C are the operands accepted with the matching `in_valid`.
- R2: Bit i of every operand and of the result is the coefficient of x^i. With the defaults m = 8 and F = 0x11B, A = 0x02, B = 0x80, C = 0 gives 0x2F, and A = 0x01, B = 0x10, C = 0 gives 0x1B.
- R3: An operand set sampled with `in_valid` high at rising edge t appears with `out_valid` high right after rising edge t+m-1, which is m edges counting edge t. `out_valid` stays low before that.
- R4: Operand sets presented on consecutive clocks produce results on consecutive clocks, with no stall.
- R5: A cycle with `in_valid` low produces a cycle with `out_valid` low, m cycles later, in its place in the output stream.
- R6: A synchronous active-high `rst` clears `out_valid` and `p_out` to 0 on the next edge. Operand sets in flight when reset is applied never show up as valid results.
- R7: With A = 0, the result equals C.
- R8: With B = 0, the result equals C.
- R9: With A = 1, the result equals C xor B².
- R10: When C equals A·B², the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on a_in, b_in, c_in are valid this cycle |
| a_in | input | M | Multiplier operand A |
| b_in | input | M | Operand B, which is squared |
| c_in | input | M | Addend C |
| out_valid | output | 1 | p_out carries a result |
| p_out | output | M | Result C + A·B² |

## Verification
The bench builds the block with its defaults: m = 8 and F = x^8 + x^4 + x^3 + x + 1. At this width every one of the eight cells and every reduction tap of the squarer is exercised with hand-computable values, such as the powers of x between x^8 and x^15. The small width also keeps the latency short enough to check each empty cycle before the first result, and to check streams mixed with bubbles and a mid-stream reset, cycle by cycle. The expected values come from a separate LSB-first reference multiplier, not from the cell algorithm.

// File: rtl/gfps_pkg.sv
package gfps_pkg;

    // Widest field the shared helper supports
    localparam int GF_MAXW = 32;

    // Default field: m = 8, F = x^8 + x^4 + x^3 + x + 1
    localparam int          DEF_M    = 8;
    localparam logic [8:0]  DEF_POLY = 9'h11B;

    // Multiply a field element by x and reduce; width m given at run time.
    function automatic logic [GF_MAXW-1:0] gf_double(
        input logic [GF_MAXW-1:0] v,
        input logic [GF_MAXW-1:0] taps,
        input int unsigned        m
    );
        logic [GF_MAXW-1:0] mask;
        logic [GF_MAXW-1:0] r;
        mask = '0;
        for (int unsigned i = 0; i < GF_MAXW; i++) begin
            if (i < m) mask[i] = 1'b1;
        end
        r = (v << 1) & mask;
        if (v[m-1]) r = r ^ (taps & mask);
        return r;
    endfunction

endpackage

// File: rtl/gfps_square.sv
module gfps_square #(
    parameter int         M    = gfps_pkg::DEF_M,
    parameter logic [M:0] POLY = gfps_pkg::DEF_POLY
) (
    input  logic [M-1:0] b_in,
    output logic [M-1:0] b2_out
);
    localparam int SW = 2 * M - 1;

    logic [SW-1:0] spread;

    always_comb begin
        spread = '0;
        for (int i = 0; i < M; i++) begin
            spread[2*i] = b_in[i];
        end
        // fold the high terms down, highest first: x^k = x^(k-M) * (F - x^M)
        for (int k = SW - 1; k >= M; k--) begin
            if (spread[k]) spread[k-M +: M] = spread[k-M +: M] ^ POLY[M-1:0];
        end
        b2_out = spread[M-1:0];
    end

endmodule

// File: rtl/gfps_cell.sv
module gfps_cell #(
    parameter int         M    = gfps_pkg::DEF_M,
    parameter logic [M:0] POLY = gfps_pkg::DEF_POLY,
    parameter bit         LAST = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic [M-1:0] p_i,
    input  logic         a_bit,
    input  logic [M-1:0] b2_i,
    input  logic [M-1:0] c_i,
    output logic         valid_o,
    output logic [M-1:0] p_o
);
    import gfps_pkg::*;

    localparam logic [GF_MAXW-1:0] TAPS = GF_MAXW'(POLY[M-1:0]);

    logic [GF_MAXW-1:0] dbl_w;
    logic [M-1:0]       next_p;

    always_comb begin
        dbl_w  = gf_double(GF_MAXW'(p_i), TAPS, M);
        next_p = dbl_w[M-1:0] ^ (a_bit ? b2_i : '0) ^ (LAST ? c_i : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            p_o     <= '0;
        end else begin
            valid_o <= valid_i;
            p_o     <= next_p;
        end
    end

    // R7: a zero partial with a clear bit of A contributes nothing but the addend
    a_r7_idle_bit: assert property (@(posedge clk) disable iff (rst)
        (!a_bit && p_i == '0) |=> (p_o == $past(LAST ? c_i : '0)));

endmodule

// File: rtl/gf_power_sum.sv
module gf_power_sum #(
    parameter int         M    = gfps_pkg::DEF_M,
    parameter logic [M:0] POLY = gfps_pkg::DEF_POLY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [M-1:0] a_in,
    input  logic [M-1:0] b_in,
    input  logic [M-1:0] c_in,
    output logic         out_valid,
    output logic [M-1:0] p_out
);
    localparam int NST = M;

    logic [M-1:0] b2_now;

    // skewed operand copies: index i feeds cell i
    logic [M-1:0] a_sk  [NST];
    logic [M-1:0] b2_sk [NST];
    logic [M-1:0] c_sk  [NST];

    // pipeline chain: index i is the input of cell i
    logic         v_ch [NST+1];
    logic [M-1:0] p_ch [NST+1];

    gfps_square #(.M(M), .POLY(POLY)) u_sq (
        .b_in   (b_in),
        .b2_out (b2_now)
    );

    assign a_sk[0]  = a_in;
    assign b2_sk[0] = b2_now;
    assign c_sk[0]  = c_in;
    assign v_ch[0]  = in_valid;
    assign p_ch[0]  = '0;

    genvar gi;
    generate
        for (gi = 1; gi < NST; gi++) begin : g_skew
            always_ff @(posedge clk) begin
                if (rst) begin
                    a_sk[gi]  <= '0;
                    b2_sk[gi] <= '0;
                    c_sk[gi]  <= '0;
                end else begin
                    a_sk[gi]  <= a_sk[gi-1];
                    b2_sk[gi] <= b2_sk[gi-1];
                    c_sk[gi]  <= c_sk[gi-1];
                end
            end
        end

        for (gi = 0; gi < NST; gi++) begin : g_cell
            gfps_cell #(
                .M    (M),
                .POLY (POLY),
                .LAST (gi == NST - 1)
            ) u_cell (
                .clk     (clk),
                .rst     (rst),
                .valid_i (v_ch[gi]),
                .p_i     (p_ch[gi]),
                .a_bit   (a_sk[gi][M-1-gi]),
                .b2_i    (b2_sk[gi]),
                .c_i     (c_sk[gi]),
                .valid_o (v_ch[gi+1]),
                .p_o     (p_ch[gi+1])
            );
        end
    endgenerate

    assign out_valid = v_ch[NST];
    assign p_out     = p_ch[NST];

    // R6: the cycle after reset shows an empty, zeroed output
    a_r6_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && p_out == '0));

    // R5: a bubble in the last cell's input becomes a bubble at the output
    a_r5_bubble_kept: assert property (@(posedge clk) disable iff (rst)
        !v_ch[NST-1] |=> !out_valid);

    // R8 / R2: the squarer maps 0 to 0 and 1 to 1
    always_comb begin
        if (!rst && b_in == '0) begin
            a_r8_square_zero: assert (b2_now == '0);
        end
        if (!rst && b_in == M'(1)) begin
            a_r2_square_one: assert (b2_now == M'(1));
        end
    end

endmodule

// File: tb/sim_gf_power_sum.sv
module sim_gf_power_sum;
    localparam int         M          = 8;
    localparam logic [M:0] POLY       = 9'h11B;
    localparam int         CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [M-1:0] a_in = '0;
    logic [M-1:0] b_in = '0;
    logic [M-1:0] c_in = '0;
    logic         out_valid;
    logic [M-1:0] p_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [M-1:0] sa [0:63];
    logic [M-1:0] sb [0:63];
    logic [M-1:0] sc [0:63];
    logic         sv [0:63];

    gf_power_sum #(.M(M), .POLY(POLY)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .c_in      (c_in),
        .out_valid (out_valid),
        .p_out     (p_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // independent LSB-first reference multiplier
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [M-1:0] r = '0;
        logic [M-1:0] t = x;
        for (int i = 0; i < M; i++) begin
            if (y[i]) r = r ^ t;
            t = t[M-1] ? ((t << 1) ^ POLY[M-1:0]) : (t << 1);
        end
        return r;
    endfunction

    function automatic logic [M-1:0] ref_ps(input logic [M-1:0] a, input logic [M-1:0] b,
                                            input logic [M-1:0] c);
        return c ^ ref_mul(a, ref_mul(b, b));
    endfunction

    task automatic chk(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0;
        a_in = '0;
        b_in = '0;
        c_in = '0;
    endtask

    // drives sa/sb/sc/sv[0..n-1] on consecutive clocks and checks each output slot
    task automatic run_stream(input string req, input int n);
        for (int k = 0; k < n + M; k++) begin
            @(negedge clk);
            if (k >= M) begin
                chk({req, " valid"}, M'(out_valid), M'(sv[k-M]));
                if (sv[k-M]) chk({req, " data"}, p_out, ref_ps(sa[k-M], sb[k-M], sc[k-M]));
            end else begin
                chk({req, " R3 early valid"}, M'(out_valid), '0);
            end
            if (k < n) begin
                in_valid = sv[k];
                a_in = sa[k];
                b_in = sb[k];
                c_in = sc[k];
            end else begin
                idle_inputs();
            end
        end
    endtask

    task automatic one_op(input string req, input logic [M-1:0] a, input logic [M-1:0] b,
                          input logic [M-1:0] c, input logic [M-1:0] exp);
        sa[0] = a; sb[0] = b; sc[0] = c; sv[0] = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; a_in = a; b_in = b; c_in = c;
        for (int k = 0; k < M; k++) begin
            @(negedge clk);
            if (k == 0) idle_inputs();
            if (k < M - 1) chk({req, " R3 not yet"}, M'(out_valid), '0);
        end
        chk({req, " R3 valid"}, M'(out_valid), M'(1));
        chk(req, p_out, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R6 reset valid", M'(out_valid), '0);
        chk("R6 reset data", p_out, '0);
        rst = 1'b0;
    endtask

    task automatic t_known();
        one_op("R2 x*x^14", 8'h02, 8'h80, 8'h00, 8'h2F);
        one_op("R2 x^8",    8'h01, 8'h10, 8'h00, 8'h1B);
    endtask

    task automatic t_special();
        one_op("R7 A zero", 8'h00, 8'hB7, 8'h5C, 8'h5C);
        one_op("R8 B zero", 8'hE1, 8'h00, 8'h3A, 8'h3A);
        one_op("R9 A one",  8'h01, 8'h9D, 8'h44, 8'h44 ^ ref_mul(8'h9D, 8'h9D));
        one_op("R10 cancel", 8'hC3, 8'h57, ref_mul(8'hC3, ref_mul(8'h57, 8'h57)), 8'h00);
        one_op("R1 all ones", 8'hFF, 8'hFF, 8'hFF, ref_ps(8'hFF, 8'hFF, 8'hFF));
    endtask

    task automatic t_back_to_back();
        for (int i = 0; i < 40; i++) begin
            sa[i] = M'($urandom);
            sb[i] = M'($urandom);
            sc[i] = M'($urandom);
            sv[i] = 1'b1;
        end
        run_stream("R4 R1 stream", 40);
    endtask

    task automatic t_bubbles();
        for (int i = 0; i < 30; i++) begin
            sa[i] = M'($urandom);
            sb[i] = M'($urandom);
            sc[i] = M'($urandom);
            sv[i] = (i % 3 != 1);
        end
        run_stream("R5 bubbles", 30);
    endtask

    task automatic t_mid_reset();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            a_in = M'($urandom | 1);
            b_in = M'($urandom | 1);
            c_in = M'($urandom);
        end
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        chk("R6 mid reset valid", M'(out_valid), '0);
        chk("R6 mid reset data", p_out, '0);
        rst = 1'b0;
        for (int k = 0; k < M + 2; k++) begin
            @(negedge clk);
            chk("R6 flushed", M'(out_valid), '0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_known();
        t_special();
        t_back_to_back();
        t_bubbles();
        t_mid_reset();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule